// File: doc/BRIEF.md
# SHA-512 Message Schedule Finisher

This block produces four new 64-bit words of the SHA-512 message schedule from a vector of partial sums and the two most recent schedule words. Each new word is its partial sum plus the small sigma-1 function of the word two positions back in the schedule. That makes the block a chain rather than four independent lanes. The first two results use the supplied history words. The last two results use the first two results, which are computed in the same operation.

A caller presents both 256-bit operands together with a one-cycle `in_valid`. One clock later, the four finished words appear on a registered output, marked by a one-cycle `out_valid`. Word width, lane count and history depth are parameters. The sigma-1 rotate and shift amounts are also parameters, and all of these are checked when the design is elaborated.

Top module: `sched2_expand`

## Requirements
- R1: Small sigma-1 of a word x is rotr(x,19) XOR rotr(x,61) XOR (x >> 6), where >> is a logical shift. Output qword 0 (bits 63:0) is partial qword 0 plus sigma-1 of history qword 2 (bits 191:128). Output qword 1 (bits 127:64) is partial qword 1 plus sigma-1 of history qword 3 (bits 255:192).
- R2: Output qword 2 is partial qword 2 plus sigma-1 of the new output qword 0. Output qword 3 is partial qword 3 plus sigma-1 of the new output qword 1. Both come from the same operation.
- R3: History qwords 0 and 1 (bits 127:0) have no effect on the result.
- R4: Every addition wraps modulo 2^64, and the carry out of bit 63 is discarded.
- R5: `out_valid` is high for exactly the one cycle after each clock edge at which `in_valid` was sampled high. Back-to-back inputs give back-to-back results.
- R6: `out_data` keeps its last value while no new operation is accepted.
- R7: A synchronous reset clears `out_valid` and `out_data` to zero. Reset takes priority over a coincident `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| in_part | input | 256 | Four partial sums, qword 0 in bits 63:0 |
| in_hist | input | 256 | Schedule history; qwords 2 and 3 used |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_data | output | 256 | Four finished schedule words |

## Verification
Each result is due one clock edge after its operands are sampled. The bench drives operands on the falling edge. It reads `out_valid` and `out_data` at the next falling edge, which comes after exactly one rising edge. It then confirms at the following falling edge that the strobe has dropped and the data has held. A second-stage lane that used the history word instead of the chained result, or a wrong rotate amount, shows up in the vector table, whose expected words come from an independent software model. Reset is checked both when idle and when it coincides with `in_valid`.

// File: rtl/sched2_pkg.sv
package sched2_pkg;
   localparam int unsigned WORD_W_DEF = 64;
   localparam int unsigned LANES_DEF  = 4;
   localparam int unsigned HIST_DEF   = 2;
endpackage

// File: rtl/sched2_sigma.sv
module sched2_sigma #(
   parameter int unsigned W     = 64,
   parameter int unsigned ROT_A = 19,
   parameter int unsigned ROT_B = 61,
   parameter int unsigned SHR_C = 6
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   generate
      if (ROT_A == 0 || ROT_A >= W || ROT_B == 0 || ROT_B >= W || SHR_C >= W) begin : g_bad
         $error("sched2_sigma: rotate/shift amount out of range");
      end
   endgenerate

   logic [W-1:0] rot_a, rot_b, shr_c;
   always_comb begin
      rot_a = (x >> ROT_A) | (x << (W - ROT_A));
      rot_b = (x >> ROT_B) | (x << (W - ROT_B));
      shr_c = x >> SHR_C;
      y     = rot_a ^ rot_b ^ shr_c;
   end
endmodule

// File: rtl/sched2_lane.sv
module sched2_lane #(
   parameter int unsigned W     = 64,
   parameter int unsigned ROT_A = 19,
   parameter int unsigned ROT_B = 61,
   parameter int unsigned SHR_C = 6
) (
   input  logic [W-1:0] partial,
   input  logic [W-1:0] back_word,
   output logic [W-1:0] word
);
   logic [W-1:0] sig;

   sched2_sigma #(.W(W), .ROT_A(ROT_A), .ROT_B(ROT_B), .SHR_C(SHR_C)) u_sig (
      .x (back_word),
      .y (sig)
   );

   // the sum is cut to W bits, so the carry out is dropped (R4)
   assign word = partial + sig;
endmodule

// File: rtl/sched2_expand.sv
module sched2_expand
   import sched2_pkg::*;
#(
   parameter int unsigned WORD_W = WORD_W_DEF,
   parameter int unsigned LANES  = LANES_DEF,
   parameter int unsigned HIST   = HIST_DEF,
   parameter int unsigned ROT_A  = 19,
   parameter int unsigned ROT_B  = 61,
   parameter int unsigned SHR_C  = 6
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [WORD_W*LANES-1:0]   in_part,
   input  logic [WORD_W*LANES-1:0]   in_hist,
   output logic                      out_valid,
   output logic [WORD_W*LANES-1:0]   out_data
);
   localparam int unsigned VEC_W     = WORD_W * LANES;
   localparam int unsigned HIST_BASE = LANES - HIST;

   generate
      if (HIST == 0 || HIST > LANES) begin : g_bad_hist
         $error("sched2_expand: HIST must be 1..LANES");
      end
      if (WORD_W < 8) begin : g_bad_w
         $error("sched2_expand: WORD_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] lane_word [LANES];
   logic [VEC_W-1:0]  next_data;

   // early lanes read history words; later lanes chain on earlier results (R1, R2)
   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         logic [WORD_W-1:0] src;
         if (gi < HIST) begin : g_from_hist
            assign src = in_hist[(HIST_BASE+gi)*WORD_W +: WORD_W];
         end else begin : g_from_chain
            assign src = lane_word[gi-HIST];
         end
         sched2_lane #(.W(WORD_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .SHR_C(SHR_C)) u_lane (
            .partial   (in_part[gi*WORD_W +: WORD_W]),
            .back_word (src),
            .word      (lane_word[gi])
         );
         assign next_data[gi*WORD_W +: WORD_W] = lane_word[gi];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= next_data;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                          // R5
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                        // R5
   AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));                                 // R6
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));                          // R7
endmodule

// File: tb/sched2_expand_test.sv
module sched2_expand_test;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [255:0] in_part, in_hist;
   logic         out_valid;
   logic [255:0] out_data;
   int           n_run = 0, n_fail = 0;
   bit           done = 0;

   always #5 clk = ~clk;

   sched2_expand uut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .in_part(in_part), .in_hist(in_hist),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [63:0] s1(input logic [63:0] x);
      return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ {6'd0, x[63:6]};
   endfunction

   function automatic logic [255:0] model(input logic [255:0] p, input logic [255:0] h);
      logic [63:0] w16, w17, w18, w19;
      w16 = p[63:0]    + s1(h[191:128]);
      w17 = p[127:64]  + s1(h[255:192]);
      w18 = p[191:128] + s1(w16);
      w19 = p[255:192] + s1(w17);
      return {w19, w18, w17, w16};
   endfunction

   localparam int NV = 5;
   localparam logic [255:0] VP [NV] = '{
      256'h0,
      {64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0f0f0f0f0f0f0f0f, 64'h1111111111111111},
      {4{64'hffffffffffffffff}},
      {64'h8000000000000000, 64'h0000000000000001, 64'hdeadbeefcafef00d, 64'h5555aaaa5555aaaa},
      {64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1}
   };
   localparam logic [255:0] VH [NV] = '{
      256'h0,
      {64'h8000000000000001, 64'h0000000000000040, 64'h0, 64'h0},
      {4{64'hffffffffffffffff}},
      {64'h7fffffffffffffff, 64'h0000000000080000, 64'h1234, 64'h5678},
      {64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179}
   };

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [255:0] p, input logic [255:0] h);
      @(negedge clk);
      in_valid = 1'b1; in_part = p; in_hist = h;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_part = '0; in_hist = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R7 reset valid", 256'(out_valid), 256'd0);
      check("R7 reset data", out_data, 256'd0);

      // vector table: R1, R2, R4
      for (int i = 0; i < NV; i++) begin
         issue(VP[i], VH[i]);
         check("R5 valid pulse", 256'(out_valid), 256'd1);
         check("R1 R2 R4 vector", out_data, model(VP[i], VH[i]));
      end

      // drop of strobe and hold of data: R5, R6
      @(negedge clk);
      check("R5 strobe drops", 256'(out_valid), 256'd0);
      check("R6 data holds", out_data, model(VP[NV-1], VH[NV-1]));
      in_part = ~in_part; in_hist = ~in_hist;
      @(negedge clk);
      check("R6 ignores idle operands", out_data, model(VP[NV-1], VH[NV-1]));

      // wrap: ffff..ffff + sigma1(1) = 2^45 + 7 (R4)
      issue({192'd0, 64'hffffffffffffffff}, {64'd0, 64'd1, 128'd0});
      check("R4 wrap q0", {192'd0, out_data[63:0]}, 256'h200000000007);

      // chain: lane 2 uses new q0, not history q0/q2 (R2)
      issue({64'd0, 64'd0, 64'd0, 64'd1}, 256'd0);
      check("R2 chain q2", {192'd0, out_data[191:128]}, {192'd0, s1(64'd1)});

      // low history qwords ignored (R3)
      issue(VP[3], {VH[3][255:128], 128'hdeadbeef_00000000_ffffffff_12345678});
      check("R3 low hist ignored", out_data, model(VP[3], {VH[3][255:128], 128'd0}));

      // back-to-back (R5)
      @(negedge clk);
      in_valid = 1'b1; in_part = VP[1]; in_hist = VH[1];
      @(negedge clk);
      check("R5 b2b first", out_data, model(VP[1], VH[1]));
      in_part = VP[4]; in_hist = VH[4];
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 b2b second valid", 256'(out_valid), 256'd1);
      check("R5 b2b second data", out_data, model(VP[4], VH[4]));

      // reset wins over in_valid (R7)
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;
      check("R7 reset over valid", 256'(out_valid), 256'd0);
      check("R7 reset clears data", out_data, 256'd0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule